// File: doc/BRIEF.md
# Programmable Tone Generator Counter

This block makes a square-wave tone from a 1 MHz timing reference. Software writes an 8-bit divisor S into a register that cannot be read back. While the two-bit mode field selects sound, a fixed divide-by-8 prescaler feeds a reload counter that expires every S+1 prescaler steps. The tone output flips each time the counter expires. A full cycle therefore lasts 16·(S+1) reference ticks, so the pitch is 1 MHz / (16·(S+1)). That spans 62.5 kHz at S=0 down to about 244 Hz at S=255.

The counter hardware is shared with the cassette paths, so tone output is locked out whenever the mode field selects cassette receive or cassette transmit. In those modes the output sits low and the counting chain is held in its idle state. A write that arrives during cassette transmit is dropped. A changed divisor never cuts short the half-period in progress: the counter picks the new value up at its next reload.

Top module: `tone_gen`

## Requirements
- R1: While mode is sound, each high and each low phase of `tone_out` lasts exactly 8·(S+1) cycles of `tick_1mhz`, where S is the stored divisor.
- R2: The output duty cycle is 50%: consecutive high and low phases have equal length.
- R3: Both ends of the divisor range hold: S=0 gives phases of 8 ticks, and S=255 gives phases of 2048 ticks.
- R4: Mode encoding is 2'b00 cassette receive, 2'b01 sound, 2'b10 cassette transmit, 2'b11 reserved. In every mode other than 2'b01, `tone_out` is low from the next clock edge on, and the prescaler and reload counter are held idle.
- R5: A write (`wr_en` high) while mode is 2'b10 leaves the stored divisor unchanged.
- R6: A write while mode is 2'b00, 2'b01 or 2'b11 stores `wr_data` as the new divisor at that clock edge.
- R7: A divisor written during a phase does not change that phase's length. It governs the phases that begin at the following reload.
- R8: After reset, `tone_out` is low and the stored divisor is 0.
- R9: `tone_out` changes in sound mode only at a clock edge where `tick_1mhz` is high and both the prescaler and the reload counter expire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1mhz | input | 1 | One-clock enable pulse at the 1 MHz reference rate |
| wr_en | input | 1 | Divisor write strobe |
| wr_data | input | 8 | Divisor value S |
| mode | input | 2 | Communications mode field (encoding in R4) |
| tone_out | output | 1 | Square-wave tone output |

## Verification
The assertions assume that `tick_1mhz` is a single-cycle pulse and that `mode` and `wr_data` are steady clock-synchronous levels, each sampled only at a rising edge. The bench produces the tick from a free-running counter, one pulse every four clocks. It changes `mode`, `wr_en` and `wr_data` only on falling edges. Divisor writes during sound mode are placed well away from a reload, so the phase that contains the write has an unambiguous expected length.

// File: rtl/tone_gen_pkg.sv
package tone_gen_pkg;

  typedef enum logic [1:0] {
    MODE_CAS_RX = 2'b00,
    MODE_SOUND  = 2'b01,
    MODE_CAS_TX = 2'b10,
    MODE_RSVD   = 2'b11
  } tone_mode_e;

  // Ticks in one half-period for divisor s with a given prescale ratio.
  function automatic int unsigned half_period_ticks(input int unsigned s,
                                                    input int unsigned prescale);
    return prescale * (s + 1);
  endfunction

  // Sound is produced only in the dedicated mode.
  function automatic logic mode_runs(input logic [1:0] m);
    return m == MODE_SOUND;
  endfunction

  // Only cassette transmit locks the divisor register.
  function automatic logic mode_locks_write(input logic [1:0] m);
    return m == MODE_CAS_TX;
  endfunction

endpackage

// File: rtl/tone_divreg.sv
module tone_divreg #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             lock,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      div_q <= '0;
    else if (wr_en && !lock)
      div_q <= wr_data;
  end

endmodule

// File: rtl/tone_prescale.sv
module tone_prescale #(
  parameter int PRESCALE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic pre_evt
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pcnt;

  assign pre_evt = run && tick && (pcnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      pcnt <= '0;
    else if (tick)
      pcnt <= (pcnt == PRE_LAST) ? '0 : pcnt + 1'b1;
  end

endmodule

// File: rtl/tone_reload_cnt.sv
module tone_reload_cnt #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_evt,
  input  logic [DIV_W-1:0] div_q,
  output logic             reload_evt
);

  logic [DIV_W-1:0] rcnt;

  assign reload_evt = run && pre_evt && (rcnt == '0);

  // Idle: keep tracking the divisor so the first phase has full length.
  always_ff @(posedge clk) begin
    if (!rst_n)
      rcnt <= '0;
    else if (!run)
      rcnt <= div_q;
    else if (pre_evt)
      rcnt <= (rcnt == '0) ? div_q : rcnt - 1'b1;
  end

endmodule

// File: rtl/tone_gen.sv
module tone_gen #(
  parameter int DIV_W    = 8,
  parameter int PRESCALE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1mhz,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  input  logic [1:0]       mode,
  output logic             tone_out
);
  import tone_gen_pkg::*;

  logic             run;
  logic             lock;
  logic [DIV_W-1:0] div_q;
  logic             pre_evt;
  logic             reload_evt;

  assign run  = mode_runs(mode);
  assign lock = mode_locks_write(mode);

  tone_divreg #(.DIV_W(DIV_W)) u_divreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .lock    (lock),
    .wr_data (wr_data),
    .div_q   (div_q)
  );

  tone_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (tick_1mhz),
    .pre_evt (pre_evt)
  );

  tone_reload_cnt #(.DIV_W(DIV_W)) u_rcnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .pre_evt    (pre_evt),
    .div_q      (div_q),
    .reload_evt (reload_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      tone_out <= 1'b0;
    else if (reload_evt)
      tone_out <= ~tone_out;
  end

endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [DIV_W-1:0] wr_data,
  input logic [1:0]       mode,
  input logic             tone_out,
  input logic             pre_evt,
  input logic             reload_evt,
  input logic [DIV_W-1:0] div_q
);

  assert_silent_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |=> !tone_out);

  assert_tx_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == 2'b10) |=> $stable(div_q));

  assert_write_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode != 2'b10) |=> (div_q == $past(wr_data)));

  assert_toggle_on_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b01 && tone_out != $past(tone_out)) |-> $past(reload_evt));

  assert_reload_needs_prescale_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |-> (pre_evt && tick));

  assert_idle_no_events_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |-> (!pre_evt && !reload_evt));

endmodule

bind tone_gen tone_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick_1mhz),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .mode       (mode),
  .tone_out   (tone_out),
  .pre_evt    (pre_evt),
  .reload_evt (reload_evt),
  .div_q      (div_q)
);

// File: tb/tone_gen_test.sv
module tone_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;        // clocks per 1 MHz tick
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1mhz;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [1:0] mode;
  logic       tone_out;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned exp_q[$];
  string       tag_q[$];
  int unsigned cyc = 0;
  int unsigned last_edge = 0;
  bit          have_last = 0;
  logic        prev_tone = 1'b0;
  bit          done = 0;
  logic [1:0]  tick_ctr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_gen uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1mhz (tick_1mhz),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .mode      (mode),
    .tone_out  (tone_out)
  );

  // Free-running reference tick, one clock high in every TICK_DIV.
  always_ff @(posedge clk) tick_ctr <= tick_ctr + 1'b1;
  assign tick_1mhz = (tick_ctr == 2'(TICK_DIV - 1));

  // Expected phase length in clocks: independent restatement of R1.
  function automatic int unsigned phase_clocks(input int unsigned s);
    return (s + 1) * 8 * TICK_DIV;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_phases(input int unsigned s, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(phase_clocks(s));
      tag_q.push_back(req);
    end
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
  endtask

  task automatic write_div(input logic [7:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
  endtask

  // Monitor: measure the clocks between output edges and pop expectations.
  always @(negedge clk) begin
    cyc++;
    if (mode != 2'b01) begin
      have_last = 0;
    end else if (tone_out !== prev_tone) begin
      if (have_last && exp_q.size() != 0) begin
        int unsigned e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check((cyc - last_edge) == e, t, int'(cyc - last_edge), int'(e));
      end
      have_last = 1;
      last_edge = cyc;
    end
    prev_tone = tone_out;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; mode = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tone_out == 1'b0, "R8 reset output", tone_out, 0);

    // R8: reset divisor is 0, so sound without a write gives S=0 phases.
    set_mode(2'b01);
    push_phases(0, 3, "R8 R1 reset divisor");
    drain();

    // R6: write in receive mode is stored.
    set_mode(2'b00);
    @(negedge clk);
    check(tone_out == 1'b0, "R4 receive mode silent", tone_out, 0);
    write_div(8'd3);
    set_mode(2'b01);
    push_phases(3, 3, "R6 R1 R2 S=3");
    drain();

    // R7: new divisor mid-phase leaves the current phase alone.
    repeat (40) @(negedge clk);
    write_div(8'd10);
    exp_q.push_back(phase_clocks(3)); tag_q.push_back("R7 current phase kept");
    push_phases(10, 2, "R7 R1 new divisor after reload");
    drain();

    // R4: leave sound while the output is high.
    wait (tone_out == 1'b1);
    @(negedge clk);
    mode = 2'b10;
    @(negedge clk);
    check(tone_out == 1'b0, "R4 transmit mode silent", tone_out, 0);

    // R5: write during transmit is dropped; S=10 remains.
    write_div(8'd200);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tone_out != 1'b0) check(0, "R4 stays low in transmit", tone_out, 0);
    end
    check(tone_out == 1'b0, "R4 low after idle window", tone_out, 0);
    set_mode(2'b01);
    push_phases(10, 2, "R5 transmit write ignored");
    drain();

    // R3: both ends of the divisor range.
    set_mode(2'b00);
    write_div(8'd0);
    set_mode(2'b01);
    push_phases(0, 4, "R3 S=0");
    drain();
    set_mode(2'b00);
    write_div(8'd255);
    set_mode(2'b01);
    push_phases(255, 2, "R3 R2 S=255");
    drain();

    // R4/R6: reserved mode is silent and accepts writes.
    wait (tone_out == 1'b1);
    @(negedge clk);
    mode = 2'b11;
    @(negedge clk);
    check(tone_out == 1'b0, "R4 reserved mode silent", tone_out, 0);
    write_div(8'd1);
    set_mode(2'b01);
    push_phases(1, 3, "R6 R9 reserved-mode write");
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule